// File: doc/BRIEF.md
# Multi-width serial memory slave front end

This block is the slave side of a serial memory link for a byte-organized store of 128K locations. A master selects it with an active-low chip enable and toggles a serial clock. The master sends an 8-bit instruction, then a 24-bit address, then data bytes. Each of the three phases runs on one, two or four data lines, and the width of each phase is picked by its own static configuration input. The block turns completed write bytes into requests on an internal memory port, and it fetches bytes through the same port to shift them back out during reads. A sequential address counter lets one command move any number of consecutive bytes.

The serial pins are brought into the system clock domain through synchronizers. The serial clock must therefore stay at least eight system clocks in each level. Each of the four data pins has separate input, output and output-enable wires. The memory request port is valid/ready. Once `mem_req_valid` is raised, the request and its address, direction and data stay unchanged until the cycle in which `mem_req_ready` is high. Read responses have no back-pressure: the memory returns `mem_rsp_valid` for one cycle with the byte. It must answer a read within five system clocks of accepting it, and it must accept any request within one byte time. The three width inputs must be held steady while chip enable is low.

Top module: `sqm_front`

## Requirements
- R1: After reset, and while chip enable is high, all four output enables are 0 and no memory request is raised.
- R2: Input bits are taken on rising serial-clock edges only, so a master may idle the clock low (mode 0) or high (mode 3) with identical results.
- R3: The first 8 bits after chip enable falls form the instruction, sent most significant bit first at the instruction width. 8'h03 starts a read and 8'h02 starts a write. Any other value makes the rest of the command ignored: no memory request and no output enable.
- R4: The next 24 bits form the address, most significant bit first at the address width. Only the low 17 bits are kept, and the upper 7 are ignored.
- R5: In a write, every completed data byte raises exactly one write request carrying the byte and its address. A partial byte at the end of a command produces no request.
- R6: In a read, output lines change only after a falling serial-clock edge. The first data group appears after the falling edge that follows the last address bit. Each byte is sent most significant bit first.
- R7: Width codes on `ins_mode`, `adr_mode` and `dat_mode` are 0 = one line, 1 = two lines and 2 = four lines (3 acts as one line). On one line, input is on line 0 and output is on line 1 with enable pattern 4'b0010. Two lines use lines 1:0 with enable 4'b0011. Four lines use lines 3:0 with enable 4'b1111. Within each group the higher-numbered line carries the higher-order bit.
- R8: After each data byte the address counter steps by one, and it wraps from 17'h1FFFF to 0.
- R9: Raising chip enable mid-command aborts it, drops all output enables and clears the bit counters. The next command then decodes from its first instruction bit.
- R10: A raised memory request keeps its valid, direction, address and data stable until accepted.
- R11: The instruction, address and data widths are independent, and every one of the 27 combinations works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip enable, active low |
| sck | input | 1 | Serial clock from the master |
| io_in | input | 4 | Input value of the four data pins |
| io_out | output | 4 | Output value of the four data pins |
| io_oe | output | 4 | Per-pin output enable |
| ins_mode | input | 2 | Instruction phase width code |
| adr_mode | input | 2 | Address phase width code |
| dat_mode | input | 2 | Data phase width code |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Request is a write (1) or a read (0) |
| mem_req_addr | output | 17 | Request byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 8 | Read response byte |

## Verification
The assertions check on every cycle the following properties:
- A stalled memory request holds steady.
- The output enables only ever take one of the three legal lane patterns.
- The enables are cleared after chip enable goes high.
- Driven output lines change only in the cycle after a detected falling serial-clock edge.

Only the bench's scenarios can show the rest:
- Bits are assembled in the right order for every mix of phase widths.
- Address and data values reach the memory port correctly.
- The burst counter steps and wraps.
- Unknown instructions and partial bytes leave the memory untouched.
- Both clock idle levels give the same results.

// File: rtl/sqm_pkg.sv
package sqm_pkg;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [1:0] {
    LN_1   = 2'd0,
    LN_2   = 2'd1,
    LN_4   = 2'd2,
    LN_RSV = 2'd3
  } lanes_e;

  typedef enum logic [2:0] {
    PH_OP,
    PH_ADR,
    PH_WR,
    PH_RD,
    PH_SKIP
  } phase_e;

  function automatic logic [2:0] lane_step(input logic [1:0] m);
    case (lanes_e'(m))
      LN_2:    return 3'd2;
      LN_4:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/sqm_sync.sv
module sqm_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sqm_rx.sv
module sqm_rx import sqm_pkg::*; #(
  parameter int SR_W  = 17,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift,
  input  logic [1:0]       mode,
  input  logic [3:0]       din,
  output logic [SR_W-1:0]  nxt,
  output logic [CNT_W-1:0] cnt_nxt
);
  logic [SR_W-1:0]  sr_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    case (lanes_e'(mode))
      LN_2:    nxt = {sr_q[SR_W-3:0], din[1:0]};
      LN_4:    nxt = {sr_q[SR_W-5:0], din};
      default: nxt = {sr_q[SR_W-2:0], din[0]};
    endcase
    cnt_nxt = cnt_q + CNT_W'(lane_step(mode));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (shift) begin
      sr_q  <= nxt;
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/sqm_tx.sv
module sqm_tx import sqm_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       step_en,
  input  logic [1:0] mode,
  input  logic [7:0] byte_in,
  output logic       at_edge,
  output logic [3:0] lines,
  output logic [3:0] mask
);
  logic [7:0] sr_q;
  logic [2:0] obit_q;

  assign at_edge = (obit_q == 3'd0);

  always_comb begin
    case (lanes_e'(mode))
      LN_2: begin
        lines = {2'b00, sr_q[7:6]};
        mask  = 4'b0011;
      end
      LN_4: begin
        lines = sr_q[7:4];
        mask  = 4'b1111;
      end
      default: begin
        lines = {2'b00, sr_q[7], 1'b0};
        mask  = 4'b0010;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      obit_q <= '0;
    end else if (clr) begin
      sr_q   <= '0;
      obit_q <= '0;
    end else if (step_en) begin
      sr_q   <= at_edge ? byte_in : (sr_q << lane_step(mode));
      obit_q <= obit_q + lane_step(mode);
    end
  end
endmodule

// File: rtl/sqm_front.sv
module sqm_front import sqm_pkg::*; #(
  parameter int ADDR_W   = 17,
  parameter int ADR_BITS = 24,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic [3:0]        io_in,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [1:0]        ins_mode,
  input  logic [1:0]        adr_mode,
  input  logic [1:0]        dat_mode,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data
);
  localparam int SR_W  = (ADDR_W > 8) ? ADDR_W : 8;
  localparam int CNT_W = $clog2(ADR_BITS + 4) + 1;

  logic       cs_s, sck_s, sck_d;
  logic [3:0] din_s;

  sqm_sync #(.W(6), .STAGES(SYNC_N), .RST_VAL(6'b100000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, sck, io_in}),
    .q({cs_s, sck_s, din_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  logic cs_act, rise, fall;
  assign cs_act = ~cs_s;
  assign rise   = cs_act & sck_s & ~sck_d;
  assign fall   = cs_act & ~sck_s & sck_d;

  phase_e            phase_q;
  logic              rd_op_q, drv_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        rd_hold_q;

  logic [1:0]       rx_mode;
  logic             rx_shift, rx_done, rx_clr;
  logic [SR_W-1:0]  rx_nxt;
  logic [CNT_W-1:0] rx_cnt_nxt, rx_target;

  assign rx_mode   = (phase_q == PH_OP)  ? ins_mode :
                     (phase_q == PH_ADR) ? adr_mode : dat_mode;
  assign rx_shift  = rise && (phase_q == PH_OP || phase_q == PH_ADR || phase_q == PH_WR);
  assign rx_target = (phase_q == PH_ADR) ? CNT_W'(ADR_BITS) : CNT_W'(8);
  assign rx_done   = rx_shift && (rx_cnt_nxt == rx_target);
  assign rx_clr    = !cs_act || rx_done;

  sqm_rx #(.SR_W(SR_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .shift(rx_shift),
    .mode(rx_mode), .din(din_s), .nxt(rx_nxt), .cnt_nxt(rx_cnt_nxt)
  );

  logic       tx_step, tx_edge, tx_load;
  logic [3:0] tx_lines, tx_mask;

  assign tx_step = fall && (phase_q == PH_RD);
  assign tx_load = tx_step && tx_edge;

  sqm_tx u_tx (
    .clk(clk), .rst_n(rst_n), .clr(!cs_act), .step_en(tx_step),
    .mode(dat_mode), .byte_in(rd_hold_q), .at_edge(tx_edge),
    .lines(tx_lines), .mask(tx_mask)
  );

  assign io_out = drv_q ? tx_lines : 4'b0000;
  assign io_oe  = drv_q ? tx_mask  : 4'b0000;

  logic              iss, iss_we;
  logic [ADDR_W-1:0] iss_addr;

  always_comb begin
    iss      = 1'b0;
    iss_we   = 1'b0;
    iss_addr = addr_q;
    case (phase_q)
      PH_ADR: if (rx_done && rd_op_q) begin
        iss      = 1'b1;
        iss_addr = rx_nxt[ADDR_W-1:0];
      end
      PH_WR: if (rx_done) begin
        iss    = 1'b1;
        iss_we = 1'b1;
      end
      PH_RD: if (tx_load) begin
        iss      = 1'b1;
        iss_addr = addr_q + ADDR_W'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OP;
      rd_op_q <= 1'b0;
      drv_q   <= 1'b0;
      addr_q  <= '0;
    end else if (!cs_act) begin
      phase_q <= PH_OP;
      drv_q   <= 1'b0;
    end else begin
      case (phase_q)
        PH_OP: if (rx_done) begin
          rd_op_q <= (rx_nxt[7:0] == OP_READ);
          phase_q <= (rx_nxt[7:0] == OP_READ || rx_nxt[7:0] == OP_WRITE) ? PH_ADR : PH_SKIP;
        end
        PH_ADR: if (rx_done) begin
          addr_q  <= rx_nxt[ADDR_W-1:0];
          phase_q <= rd_op_q ? PH_RD : PH_WR;
        end
        PH_WR: if (rx_done) addr_q <= addr_q + ADDR_W'(1);
        PH_RD: if (tx_load) begin
          drv_q  <= 1'b1;
          addr_q <= addr_q + ADDR_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rd_hold_q <= '0;
    else if (mem_rsp_valid) rd_hold_q <= mem_rsp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req_valid <= 1'b0;
      mem_req_we    <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
    end else if (iss) begin
      mem_req_valid <= 1'b1;
      mem_req_we    <= iss_we;
      mem_req_addr  <= iss_addr;
      mem_req_wdata <= rx_nxt[7:0];
    end else if (mem_req_ready) begin
      mem_req_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sqm_front_chk.sv
module sqm_front_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              fall,
  input logic [3:0]        io_out,
  input logic [3:0]        io_oe,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [7:0]        mem_req_wdata
);
  // R10: stalled request is held unchanged
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr) && $stable(mem_req_wdata));

  // R7: only the three lane patterns can be enabled
  a_r7_oe_shape: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe == 4'b0000 || io_oe == 4'b0010 || io_oe == 4'b0011 || io_oe == 4'b1111);

  // R9 and R1: inactive chip enable leaves the pins undriven
  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> io_oe == 4'b0000 && io_out == 4'b0000);

  // R6: driven lines move only after a falling serial-clock edge
  a_r6_change_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe != 4'b0000 && $past(io_oe) != 4'b0000 && !$past(fall) |-> $stable(io_out));
endmodule

bind sqm_front sqm_front_chk #(.ADDR_W(ADDR_W)) chk (.*);

// File: tb/sqm_front_test.sv
`timescale 1ns/1ps
module sqm_front_test;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic [3:0]  io_in = 4'b0;
  logic [3:0]  io_out, io_oe;
  logic [1:0]  ins_mode = 2'd0, adr_mode = 2'd0, dat_mode = 2'd0;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [16:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = 8'h00;

  always #2 clk = ~clk;

  sqm_front uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .ins_mode(ins_mode), .adr_mode(adr_mode),
    .dat_mode(dat_mode), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [7:0] fexp(input logic [16:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd37;
    return m ^ a[15:8] ^ {7'd0, a[16]};
  endfunction

  function automatic logic [7:0] wd(input int i, input int c);
    logic [7:0] m;
    m = 8'(i) * 8'd29;
    return 8'hA5 ^ m ^ 8'(c);
  endfunction

  function automatic logic [3:0] oe_exp(input int w);
    return (w == 2) ? 4'b1111 : (w == 1) ? 4'b0011 : 4'b0010;
  endfunction

  // memory model
  int wr_n = 0, rd_n = 0, tick = 0;
  logic [16:0] wr_a [16];
  logic [7:0]  wr_d [16];
  bit          pend = 0;
  logic [16:0] pend_a = '0;

  always @(negedge clk) begin
    mem_rsp_valid = pend;
    mem_rsp_data  = fexp(pend_a);
    pend = 0;
    tick++;
    mem_req_ready = rst_n && ((tick % 3) != 0);
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        if (wr_n < 16) begin
          wr_a[wr_n] = mem_req_addr;
          wr_d[wr_n] = mem_req_wdata;
        end
        wr_n++;
      end else begin
        pend = 1;
        pend_a = mem_req_addr;
        rd_n++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(posedge clk);
    #1;
  endtask

  task automatic begin_cmd(input bit m3);
    sck = m3;
    half();
    cs_n = 1'b0;
    half();
  endtask

  task automatic end_cmd(input bit m3);
    if (!m3) begin
      sck = 1'b0;
      half();
    end
    cs_n = 1'b1;
    repeat (4) half();
  endtask

  task automatic send(input logic [31:0] v, input int nbits, input int w);
    int st;
    logic [3:0] g;
    st = 1 << w;
    for (int k = nbits - st; k >= 0; k -= st) begin
      g = 4'((v >> k) & ((1 << st) - 1));
      sck = 1'b0;
      io_in = g;
      half();
      sck = 1'b1;
      half();
    end
  endtask

  task automatic recv(input int w, input int ng, output logic [7:0] b, output bit oe_ok);
    int st;
    logic [3:0] g;
    st = 1 << w;
    b = '0;
    oe_ok = 1;
    for (int k = 0; k < ng; k++) begin
      sck = 1'b0;
      half();
      if (w == 2)      g = io_out;
      else if (w == 1) g = {2'b00, io_out[1:0]};
      else             g = {3'b000, io_out[1]};
      if (io_oe != oe_exp(w)) oe_ok = 0;
      b = 8'((b << st) | g);
      sck = 1'b1;
      half();
    end
  endtask

  task automatic do_write(input bit m3, input int iw, input int aw, input int dw,
                          input logic [23:0] a, input int nb, input int c);
    ins_mode = 2'(iw); adr_mode = 2'(aw); dat_mode = 2'(dw);
    wr_n = 0;
    begin_cmd(m3);
    send(32'h02, 8, iw);
    send({8'h00, a}, 24, aw);
    for (int i = 0; i < nb; i++) send({24'h0, wd(i, c)}, 8, dw);
    end_cmd(m3);
  endtask

  task automatic do_read(input bit m3, input int iw, input int aw, input int dw,
                         input logic [23:0] a, input int nb, input string tag);
    logic [7:0] b;
    logic [16:0] ea;
    bit ok;
    ins_mode = 2'(iw); adr_mode = 2'(aw); dat_mode = 2'(dw);
    begin_cmd(m3);
    send(32'h03, 8, iw);
    send({8'h00, a}, 24, aw);
    for (int i = 0; i < nb; i++) begin
      recv(dw, 8 >> dw, b, ok);
      ea = 17'(a[16:0] + 17'(i));
      check(b == fexp(ea), tag, b, fexp(ea));
      check(ok, "R7 read output enable pattern", io_oe, oe_exp(dw));
    end
    end_cmd(m3);
  endtask

  initial begin
    repeat (1000 * 190) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    bit ok;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    // R1: reset state
    check(io_oe == 4'b0, "R1 reset output enable", io_oe, 0);
    check(mem_req_valid == 1'b0, "R1 reset request", mem_req_valid, 0);

    // R11 sweep over all width combinations, R2 alternates clock idle level
    for (int c = 0; c < 27; c++) begin
      int iw, aw, dw;
      bit m3;
      logic [16:0] base;
      iw = c % 3; aw = (c / 3) % 3; dw = c / 9;
      m3 = c[0];
      base = 17'((c * 4099 + 17'h1FFFE * (c == 13 ? 1 : 0)) & 17'h1FFFF);
      do_write(m3, iw, aw, dw, {7'h55, base}, 3, c);
      check(wr_n == 3, "R5 R11 write request count", wr_n, 3);
      for (int i = 0; i < 3; i++) begin
        logic [16:0] ea;
        ea = 17'(base + 17'(i));
        check(wr_a[i] == ea, "R4 R8 write address", wr_a[i], ea);
        check(wr_d[i] == wd(i, c), "R10 R2 write data", wr_d[i], wd(i, c));
      end
      do_read(m3, iw, aw, dw, {7'h2A, base}, 3, "R6 R11 read byte");
    end

    // R8 wrap on write and read, upper address bits ignored (R4)
    do_write(1'b0, 0, 0, 0, 24'hFFFFFF, 2, 7);
    check(wr_n == 2, "R8 wrap write count", wr_n, 2);
    check(wr_a[0] == 17'h1FFFF, "R4 upper bits ignored", wr_a[0], 17'h1FFFF);
    check(wr_a[1] == 17'h00000, "R8 write wrap address", wr_a[1], 0);
    do_read(1'b0, 2, 2, 1, 24'h81FFFE, 3, "R8 read across wrap");

    // R2 mode 3 quad read
    do_read(1'b1, 2, 2, 2, 24'h00ABCD, 2, "R2 mode 3 read");

    // R3 unknown instruction ignored
    wr_n = 0; rd_n = 0;
    ins_mode = 2'd0; adr_mode = 2'd0; dat_mode = 2'd0;
    begin_cmd(1'b0);
    send(32'h9F, 8, 0);
    send(32'h000010, 24, 0);
    recv(0, 8, b, ok);
    check(io_oe == 4'b0, "R3 unknown opcode no drive", io_oe, 0);
    send(32'h5A, 8, 0);
    end_cmd(1'b0);
    check(wr_n == 0, "R3 unknown opcode no write", wr_n, 0);
    check(rd_n == 0, "R3 unknown opcode no read", rd_n, 0);

    // R5 partial byte discarded, R9 abort then fresh decode
    do_write(1'b0, 0, 0, 0, 24'h000100, 1, 3);
    wr_n = 0;
    begin_cmd(1'b0);
    send(32'h02, 8, 0);
    send(32'h000200, 24, 0);
    send(32'hC3, 8, 0);
    send(32'hA, 4, 0);
    end_cmd(1'b0);
    check(wr_n == 1, "R5 partial byte dropped", wr_n, 1);
    check(wr_d[0] == 8'hC3, "R5 full byte kept", wr_d[0], 8'hC3);
    wr_n = 0;
    begin_cmd(1'b0);
    send(32'h02, 8, 0);
    send(32'h000300, 24, 0);
    send(32'h3C, 8, 0);
    end_cmd(1'b0);
    check(wr_n == 1 && wr_a[0] == 17'h300, "R9 fresh decode after abort", wr_a[0], 17'h300);

    // R9 abort during read drops enables
    dat_mode = 2'd0;
    begin_cmd(1'b0);
    send(32'h03, 8, 0);
    send(32'h000040, 24, 0);
    recv(0, 8, b, ok);
    check(b == fexp(17'h40), "R6 single read before abort", b, fexp(17'h40));
    recv(0, 3, b, ok);
    check(io_oe == 4'b0010, "R7 single lane enable mid byte", io_oe, 4'b0010);
    sck = 1'b0;
    half();
    cs_n = 1'b1;
    half();
    check(io_oe == 4'b0, "R9 abort drops enable", io_oe, 0);
    check(io_out == 4'b0, "R9 abort output idle", io_out, 0);
    repeat (4) half();
    do_read(1'b0, 1, 1, 1, 24'h000041, 1, "R9 read after abort");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule